// File: doc/BRIEF.md
# Serial Lane Deserializer with Preset Word Aligner

This block turns one source-synchronous serial lane into parallel words. Each rising edge of the bit clock shifts one serial bit into a shift register. The first bit of a word lands in the most significant position. A word-rate enable marks the bit period that completes each word. On that edge the completed word is rotated by the current slip count and loaded into an output holding register. The holding register keeps its value until the next word boundary.

The slip count selects where the word boundary falls. A count of zero means that the bits loaded at the enabled edge are output unchanged. Each added step rotates the output word right by one position, and the lowest bit wraps round into the top. Asserting the alignment reset loads the count from a per-instance parameter, so a fixed board-level alignment needs no runtime pulse train. Training logic can still move the count afterwards with slip pulses. Each pulse is edge-detected and applied once, at the next word boundary. The active count is brought out so that it can be observed.

Top module: `deser_bitslip_rx`

## Requirements
- R1: With a slip count of 0, the holding output on the cycle after the enabled edge equals the last W serial bits. The earliest of these bits is at bit W-1 and the bit sampled on the enabled edge is at bit 0.
- R2: With slip count k, the held word is the captured word rotated right by k places. Output bit i takes captured bit (i+k) mod W, so bit 0 wraps into bit W-1.
- R3: A high alignment reset at a clock edge sets the slip count to the parameter SLIP_PRESET on the next cycle.
- R4: The slip count stays within 0..W-1, and one increment from W-1 gives 0.
- R5: A slip request held high for many cycles advances the count by exactly one.
- R6: A rising edge on the slip request raises the count by one at the next enabled edge that comes after the rising edge's own cycle. The word loaded at that same enabled edge still uses the old count. A rising edge that coincides with an enabled edge therefore takes effect one word later.
- R7: A rising edge on the slip request that comes while the alignment reset is high is discarded. When both are high together, the count is loaded with SLIP_PRESET and does not advance.
- R8: The holding output and the slip count do not change on clock edges where the word enable and the alignment reset are both low.
- R9: While the active-low reset is asserted, the holding output is all zeros and the slip count equals SLIP_PRESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data, earliest bit of each word first |
| word_en | input | 1 | High during the bit period that completes a word |
| align_rst | input | 1 | Loads the slip count from SLIP_PRESET |
| slip_req | input | 1 | Slip request; each rising edge counts once |
| par_out | output | W | Aligned parallel word, held between word boundaries |
| slip_cnt | output | $clog2(W) | Active slip count |

## Verification
Two pairs of events can land in the same cycle. The first pair is a slip rising edge and a word boundary. The bench places a one-cycle slip pulse on every bit position of a word, including the enabled bit. After each word and after the word that follows, it compares the count with a bench model. The second pair is a slip edge and an alignment reset. The bench raises both together and requires the count to equal the preset. Data checks sweep every W-bit pattern at every slip count, and the expected rotation is computed arithmetically.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // Modular successor used for the slip counter and its checker.
    function automatic int wrap_next(input int value, input int modulus);
        return (value >= modulus - 1) ? 0 : value + 1;
    endfunction

endpackage

// File: rtl/deser_shift.sv
// Serial-in shift register. Exposes the word that would be complete if
// the current bit were the last one of a word.
module deser_shift #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [W-1:0] cap_word
);
    typedef struct packed {
        logic [W-1:0] sr;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        cap_word = {st_q.sr[W-2:0], ser_in};
        st_d     = st_q;
        st_d.sr  = cap_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/deser_slip_ctrl.sv
// Slip counter: preset on alignment reset, edge-detected increments
// applied at the next word boundary.
module deser_slip_ctrl #(
    parameter int W           = 7,
    parameter int SLIP_PRESET = 0,
    parameter int CW          = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_en,
    input  logic          align_rst,
    input  logic          slip_req,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] PRESET_V = CW'(SLIP_PRESET);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev;
        logic          pend;
    } slip_state_t;

    slip_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d      = st_q;
        rise      = slip_req & ~st_q.prev;
        st_d.prev = slip_req;
        if (align_rst) begin
            st_d.cnt  = PRESET_V;
            st_d.pend = 1'b0;
        end else begin
            if (word_en && st_q.pend) begin
                st_d.cnt = CW'(deser_pkg::wrap_next(int'(st_q.cnt), W));
            end
            st_d.pend = (st_q.pend & ~word_en) | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= PRESET_V;
            st_q.prev <= 1'b0;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/deser_rotator.sv
// Combinational right rotation by a run-time amount.
module deser_rotator #(
    parameter int W  = 7,
    parameter int CW = 3
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amount,
    output logic [W-1:0]  dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            dout[i] = din[i];
            for (int j = 0; j < W; j++) begin
                if (amount == CW'(j)) dout[i] = din[(i + j) % W];
            end
        end
    end
endmodule

// File: rtl/deser_bitslip_rx.sv
module deser_bitslip_rx #(
    parameter int W           = 7,
    parameter int SLIP_PRESET = 0,
    localparam int CW         = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic          word_en,
    input  logic          align_rst,
    input  logic          slip_req,
    output logic [W-1:0]  par_out,
    output logic [CW-1:0] slip_cnt
);
    typedef struct packed {
        logic [W-1:0] hold;
    } out_state_t;

    logic [W-1:0] cap_word;
    logic [W-1:0] rot_word;
    out_state_t   st_d, st_q;

    deser_shift #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .cap_word (cap_word)
    );

    deser_slip_ctrl #(.W(W), .SLIP_PRESET(SLIP_PRESET), .CW(CW)) u_slip (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_en   (word_en),
        .align_rst (align_rst),
        .slip_req  (slip_req),
        .cnt       (slip_cnt)
    );

    deser_rotator #(.W(W), .CW(CW)) u_rot (
        .din    (cap_word),
        .amount (slip_cnt),
        .dout   (rot_word)
    );

    always_comb begin
        st_d = st_q;
        if (word_en) st_d.hold = rot_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_out = st_q.hold;
endmodule

// File: rtl/deser_bitslip_rx_chk.sv
module deser_bitslip_rx_chk #(
    parameter int W           = 7,
    parameter int SLIP_PRESET = 0,
    parameter int CW          = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          word_en,
    input logic          align_rst,
    input logic [W-1:0]  cap_word,
    input logic [W-1:0]  par_out,
    input logic [CW-1:0] slip_cnt
);
    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        align_rst |=> (slip_cnt == CW'(SLIP_PRESET))); // R3

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slip_cnt) < W); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_en && !align_rst) |=> ((slip_cnt == $past(slip_cnt)) ||
            (int'(slip_cnt) == deser_pkg::wrap_next(int'($past(slip_cnt)), W)))); // R4

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_en && !align_rst) |=> $stable(slip_cnt)); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_en |=> $stable(par_out)); // R8

    AST_ROT_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        word_en |=> ($countones(par_out) == $countones($past(cap_word)))); // R2
endmodule

bind deser_bitslip_rx deser_bitslip_rx_chk #(.W(W), .SLIP_PRESET(SLIP_PRESET), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_en   (word_en),
    .align_rst (align_rst),
    .cap_word  (cap_word),
    .par_out   (par_out),
    .slip_cnt  (slip_cnt)
);

// File: tb/sim_deser_bitslip_rx.sv
module sim_deser_bitslip_rx;
    localparam int W      = 5;
    localparam int PRESET = 3;
    localparam int CW     = $clog2(W);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_in = 1'b0, word_en = 1'b0, align_rst = 1'b0, slip_req = 1'b0;
    logic [W-1:0]  par_out;
    logic [CW-1:0] slip_cnt;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model state
    logic [W-1:0] m_sr, m_exp;
    int m_cnt;
    bit m_prev, m_pend;

    always #10 clk = ~clk;

    deser_bitslip_rx #(.W(W), .SLIP_PRESET(PRESET)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .word_en(word_en),
        .align_rst(align_rst), .slip_req(slip_req),
        .par_out(par_out), .slip_cnt(slip_cnt)
    );

    function automatic logic [W-1:0] rotr(input logic [W-1:0] d, input int k);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = d[(i + k) % W];
        return r;
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One bit period: drive at the falling edge, update the model after the rising edge.
    task automatic step(input bit s, input bit we, input bit ar, input bit sl);
        logic [W-1:0] cap;
        bit rise;
        ser_in = s; word_en = we; align_rst = ar; slip_req = sl;
        @(posedge clk);
        cap  = {m_sr[W-2:0], s};
        rise = sl && !m_prev;
        if (we) m_exp = rotr(cap, m_cnt);
        if (ar) begin
            m_cnt = PRESET; m_pend = 1'b0;
        end else begin
            if (we && m_pend) m_cnt = (m_cnt + 1) % W;
            m_pend = (m_pend && !we) || rise;
        end
        m_prev = sl;
        m_sr   = cap;
        @(negedge clk);
    endtask

    // One word; slip_mask/ar_mask bit j applies to bit period j.
    task automatic send_word(input logic [W-1:0] data, input logic [W-1:0] slip_mask,
                             input logic [W-1:0] ar_mask, input string req);
        logic [W-1:0] held;
        for (int j = 0; j < W; j++) begin
            step(data[W-1-j], j == W-1, ar_mask[j], slip_mask[j]);
            if (j == W/2 && ar_mask == '0) begin
                held = m_exp;
                chk(int'(par_out), int'(held), "R8 holding output mid-word");
            end
        end
        chk(int'(par_out), int'(m_exp), req);
        chk(int'(slip_cnt), m_cnt, req);
    endtask

    initial begin
        m_sr = '0; m_exp = '0; m_cnt = PRESET; m_prev = 1'b0; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        chk(int'(par_out), 0, "R9 reset output");
        chk(int'(slip_cnt), PRESET, "R9 reset slip count");
        rst_n = 1'b1;
        @(negedge clk);

        // R3: alignment reset loads the preset
        step(1'b0, 1'b0, 1'b1, 1'b0);
        chk(int'(slip_cnt), PRESET, "R3 preset after align reset");

        // R1/R2: every pattern at every slip count; a pulse at bit 0 of the
        // last word advances the count (R4 wrap happens on the way).
        for (int c = 0; c < W; c++) begin
            for (int d = 0; d < (1 << W); d++) begin
                send_word(W'(d), (d == (1 << W) - 1) ? W'(1) : W'(0), '0,
                          (m_cnt == 0) ? "R1 zero-slip capture" : "R2 rotated capture");
            end
        end
        chk(int'(slip_cnt), PRESET, "R4 count wrapped back to preset");

        // R6: pulse at each bit position
        for (int p = 0; p < W; p++) begin
            send_word(W'(5'b10110), W'(1) << p, '0, "R6 slip pulse position");
            send_word(W'(5'b01101), '0, '0, "R6 slip applied one word later");
        end

        // R5: slip held high through two words counts once
        send_word(W'(5'b11001), '1, '0, "R5 held slip first word");
        send_word(W'(5'b11001), '1, '0, "R5 held slip second word");
        send_word(W'(5'b00011), '0, '0, "R5 after release");

        // R4: walk the count to W-1 and step once more
        while (m_cnt != W - 1) send_word(W'(5'b10000), W'(1), '0, "R4 walking");
        send_word(W'(5'b10000), W'(1), '0, "R4 step from top");
        send_word(W'(5'b10000), '0, '0, "R4 wrap to zero");
        chk(int'(slip_cnt), 0, "R4 wrapped count");

        // R7: slip edge together with alignment reset, and slip on the word edge under reset
        send_word(W'(5'b01011), W'(5'b00100), W'(5'b00100), "R7 slip during align reset");
        chk(int'(slip_cnt), PRESET, "R7 preset wins");
        send_word(W'(5'b01011), '0, '0, "R7 no deferred slip");
        chk(int'(slip_cnt), PRESET, "R7 count unchanged");
        send_word(W'(5'b11100), W'(5'b10000), W'(5'b11111), "R7 slip on boundary under reset");
        send_word(W'(5'b11100), '0, '0, "R7 still preset");
        chk(int'(slip_cnt), PRESET, "R7 preset held");

        // R9: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk(int'(par_out), 0, "R9 reset clears output");
        chk(int'(slip_cnt), PRESET, "R9 reset restores preset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule